// File: doc/BRIEF.md
# Framed Synchronous Serial Port Transceiver

This block is the 16-bit bidirectional serial link between a voiceband codec and its host signal processor. It derives the serial clock from the master clock by dividing it by five, with an uneven split of three master periods low and two high. Once per 8 kHz frame it loads one parallel word from the codec core and shifts it out most significant bit first, announced by its own one-period output frame sync.

In the other direction the host frames each inbound word with a one-period input sync. The port captures the level of a word-type line (data or control) together with that sync, shifts in the sixteen bits that follow, and hands the word and its type to the core with a single-cycle valid strobe. A chip-select input can release the pads: while it is low the output-enable drops, the serial outputs are held low internally and every serial input is ignored. A transfer that is cut by chip select is lost. Interpreting received words is left to the core.

Top module: `vsp_serial_port`

## Requirements
- R1: `ser_clk` repeats every 5 `clk` cycles, low for 3 and high for 2; it is low during reset and first rises at the third `clk` edge after reset is released.
- R2: `out_sync` goes high at a rising edge of `ser_clk`, stays high for exactly one serial period, first appears at the first rising edge after reset and recurs every 325 serial periods (1625 `clk` cycles).
- R3: The word on `tx_word` is sampled at the frame-sync edge (`tx_take` pulses for one cycle after it) and appears on `ser_out` MSB first at the 16 rising edges that follow the frame sync; otherwise `ser_out` is low, and it changes only at rising edges of `ser_clk`.
- R4: `in_sync` seen high at a falling edge of `ser_clk` opens a word; `ser_in` is sampled at the next 16 falling edges MSB first, and `rx_valid` is high for one `clk` cycle right after the 16th sample with the word on `rx_word`.
- R5: `word_type` is sampled at the same falling edge as `in_sync`, and `rx_is_data` presents that level with the word (1 = data word, 0 = control word).
- R6: `in_sync` high at the falling edges of bits 15 down to 1 of a word is ignored; high at the falling edge of the LSB it opens the next word back to back.
- R7: While `cs` is low, `pins_en` is low, `ser_clk`, `ser_out` and `out_sync` read low and serial inputs cause no received word.
- R8: `cs` falling during an inbound word discards it (no `rx_valid`); falling during an outbound word stops it, and `ser_out` stays low until the next frame sync.
- R9: During reset `pins_en` follows `cs`, `ser_clk`, `ser_out`, `out_sync` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, high enables the port |
| ser_in | input | 1 | Inbound serial data |
| in_sync | input | 1 | Inbound frame sync from the host |
| word_type | input | 1 | Word type level sampled with `in_sync` (1 data, 0 control) |
| tx_word | input | 16 | Parallel word to send in the coming frame |
| ser_clk | output | 1 | Serial clock |
| ser_out | output | 1 | Outbound serial data |
| out_sync | output | 1 | Outbound frame sync |
| pins_en | output | 1 | Pad output enable for `ser_clk`, `ser_out`, `out_sync` |
| tx_take | output | 1 | One-cycle pulse: `tx_word` has been loaded |
| rx_valid | output | 1 | One-cycle strobe: a received word is presented |
| rx_word | output | 16 | Received word |
| rx_is_data | output | 1 | Type of the received word |

## Verification
Inbound words sweep all-zero, all-one, single-edge bits and every walking one with alternating type levels, which separates bit-order, bit-slip and type-capture faults. Back-to-back words chained by a sync in the LSB cycle and a word with a stray mid-word sync tell correct sync masking apart from early restarts. Chip select is pulled low for a whole word, in the middle of an inbound word and in the middle of an outbound word, distinguishing discard from corruption, while an LFSR-driven outbound word stream and a fixed waveform count check the clock split and frame spacing.

// File: rtl/vsp_pkg.sv
`timescale 1ns/1ps
package vsp_pkg;
    localparam int unsigned VSP_WORD_W   = 16;
    localparam int unsigned VSP_DIV      = 5;
    localparam int unsigned VSP_LOW_LEN  = 3;
    localparam int unsigned VSP_FRAME_LEN = 325;

    // Kind of an inbound word, level of the type line at the sync sample.
    typedef enum logic {
        KIND_CTRL = 1'b0,
        KIND_DATA = 1'b1
    } word_kind_e;

    // One-cycle-ahead strobes: the coming clk edge is a serial rise / fall.
    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    typedef struct packed {
        logic [VSP_WORD_W-1:0] bits;
        word_kind_e            kind;
    } rx_word_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vsp_sclk_gen.sv
`timescale 1ns/1ps
module vsp_sclk_gen
    import vsp_pkg::*;
#(
    parameter int unsigned DIV     = VSP_DIV,
    parameter int unsigned LOW_LEN = VSP_LOW_LEN
) (
    input  logic      clk,
    input  logic      rst,
    output logic      sclk,
    output sclk_evt_t evt
);
    localparam int unsigned PW = cnt_w(DIV);

    logic [PW-1:0] ph;
    logic [PW-1:0] ph_nx;

    always_comb begin
        ph_nx    = (ph == PW'(DIV - 1)) ? '0 : ph + PW'(1);
        evt.rise = (ph_nx == PW'(LOW_LEN));
        evt.fall = (ph_nx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= '0;
            sclk <= 1'b0;
        end else begin
            ph   <= ph_nx;
            sclk <= (ph_nx >= PW'(LOW_LEN));
        end
    end
endmodule

// File: rtl/vsp_tx.sv
`timescale 1ns/1ps
module vsp_tx
    import vsp_pkg::*;
#(
    parameter int unsigned WORD_W    = VSP_WORD_W,
    parameter int unsigned FRAME_LEN = VSP_FRAME_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rise,
    input  logic [WORD_W-1:0] word_in,
    output logic              sync_q,
    output logic              sdo_q,
    output logic              take
);
    localparam int unsigned FW = cnt_w(FRAME_LEN);
    localparam int unsigned CW = cnt_w(WORD_W);

    logic [FW-1:0]     fcnt;
    logic [WORD_W-1:0] sh;
    logic [CW-1:0]     left;
    logic              frame_start;

    assign frame_start = rise && (fcnt == FW'(FRAME_LEN - 1));

    // Free-running frame timer; reset to the last slot so the first frame
    // starts at the first serial rising edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt <= FW'(FRAME_LEN - 1);
        end else if (rise) begin
            fcnt <= frame_start ? '0 : fcnt + FW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            sdo_q  <= 1'b0;
            sh     <= '0;
            left   <= '0;
            take   <= 1'b0;
        end else begin
            take <= 1'b0;
            if (!cs) begin
                sync_q <= 1'b0;
                sdo_q  <= 1'b0;
                left   <= '0;
            end else if (rise) begin
                sync_q <= frame_start;
                if (sync_q) begin
                    sdo_q <= sh[WORD_W-1];
                    sh    <= sh << 1;
                    left  <= CW'(WORD_W - 1);
                end else if (left != '0) begin
                    sdo_q <= sh[WORD_W-1];
                    sh    <= sh << 1;
                    left  <= left - CW'(1);
                end else begin
                    sdo_q <= 1'b0;
                end
                if (frame_start) begin
                    sh   <= word_in;
                    take <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vsp_rx.sv
`timescale 1ns/1ps
module vsp_rx
    import vsp_pkg::*;
#(
    parameter int unsigned WORD_W = VSP_WORD_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs,
    input  logic     fall,
    input  logic     sdi,
    input  logic     fs,
    input  logic     kind_in,
    output logic     valid,
    output rx_word_t word_out
);
    localparam int unsigned CW = cnt_w(WORD_W + 1);

    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] sh_nx;
    word_kind_e        kind_pend;

    assign sh_nx = {sh[WORD_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            sh        <= '0;
            kind_pend <= KIND_CTRL;
            valid     <= 1'b0;
            word_out  <= '{bits: '0, kind: KIND_CTRL};
        end else begin
            valid <= 1'b0;
            if (!cs) begin
                cnt <= '0;
            end else if (fall) begin
                if (cnt == '0) begin
                    if (fs) begin
                        cnt       <= CW'(WORD_W);
                        kind_pend <= word_kind_e'(kind_in);
                    end
                end else begin
                    sh  <= sh_nx;
                    cnt <= cnt - CW'(1);
                    if (cnt == CW'(1)) begin
                        word_out <= '{bits: sh_nx, kind: kind_pend};
                        valid    <= 1'b1;
                        if (fs) begin
                            cnt       <= CW'(WORD_W);
                            kind_pend <= word_kind_e'(kind_in);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vsp_serial_port.sv
`timescale 1ns/1ps
module vsp_serial_port
    import vsp_pkg::*;
#(
    parameter int unsigned WORD_W    = VSP_WORD_W,
    parameter int unsigned DIV       = VSP_DIV,
    parameter int unsigned LOW_LEN   = VSP_LOW_LEN,
    parameter int unsigned FRAME_LEN = VSP_FRAME_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              ser_in,
    input  logic              in_sync,
    input  logic              word_type,
    input  logic [WORD_W-1:0] tx_word,
    output logic              ser_clk,
    output logic              ser_out,
    output logic              out_sync,
    output logic              pins_en,
    output logic              tx_take,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_is_data
);
    sclk_evt_t evt;
    logic      sclk_int;
    logic      ofs_int;
    logic      sdo_int;
    rx_word_t  rx_q;

    vsp_sclk_gen #(.DIV(DIV), .LOW_LEN(LOW_LEN)) u_clkgen (
        .clk (clk),
        .rst (rst),
        .sclk(sclk_int),
        .evt (evt)
    );

    vsp_tx #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .cs     (cs),
        .rise   (evt.rise),
        .word_in(tx_word),
        .sync_q (ofs_int),
        .sdo_q  (sdo_int),
        .take   (tx_take)
    );

    vsp_rx #(.WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .fall    (evt.fall),
        .sdi     (ser_in),
        .fs      (in_sync),
        .kind_in (word_type),
        .valid   (rx_valid),
        .word_out(rx_q)
    );

    // Pads are released by cs; internally the outputs read low meanwhile.
    assign pins_en    = cs;
    assign ser_clk    = cs & sclk_int;
    assign ser_out    = cs & sdo_int;
    assign out_sync   = cs & ofs_int;
    assign rx_word    = rx_q.bits;
    assign rx_is_data = (rx_q.kind == KIND_DATA);
endmodule

// File: rtl/vsp_port_chk.sv
`timescale 1ns/1ps
module vsp_port_chk (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic sclk_int,
    input logic ofs_int,
    input logic sdo_int,
    input logic rx_valid
);
    p_sclk_low_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_int) |-> (!$past(sclk_int, 2) && !$past(sclk_int, 3)));

    p_sclk_high_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_int) |=> (sclk_int ##1 !sclk_int));

    p_sync_edge_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ofs_int) |-> $rose(sclk_int));

    p_sync_width_r2: assert property (@(posedge clk) disable iff (rst || !cs)
        $rose(ofs_int) |=> (ofs_int ##1 ofs_int ##1 ofs_int ##1 ofs_int ##1 !ofs_int));

    p_sdo_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdo_int) && $past(cs)) |-> $rose(sclk_int));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_quiet_rx_r7: assert property (@(posedge clk) disable iff (rst)
        !cs |=> !rx_valid);
endmodule

bind vsp_serial_port vsp_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .sclk_int(sclk_int),
    .ofs_int (ofs_int),
    .sdo_int (sdo_int),
    .rx_valid(rx_valid)
);

// File: tb/tb_vsp_serial_port.sv
`timescale 1ns/1ps
module tb_vsp_serial_port;
    localparam int W = 16;
    localparam int DIV = 5;
    localparam int FRAME = 325;
    localparam int FCYC = DIV * FRAME;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b1;
    logic ser_in = 1'b0;
    logic in_sync = 1'b0;
    logic word_type = 1'b0;
    logic [W-1:0] tx_word = 16'hA5C3;
    logic ser_clk, ser_out, out_sync, pins_en, tx_take, rx_valid, rx_is_data;
    logic [W-1:0] rx_word;

    vsp_serial_port dut (
        .clk(clk), .rst(rst), .cs(cs), .ser_in(ser_in), .in_sync(in_sync),
        .word_type(word_type), .tx_word(tx_word), .ser_clk(ser_clk),
        .ser_out(ser_out), .out_sync(out_sync), .pins_en(pins_en),
        .tx_take(tx_take), .rx_valid(rx_valid), .rx_word(rx_word),
        .rx_is_data(rx_is_data)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Outbound monitor: behaves as the host receiver.
    bit mon_on = 1'b0;
    int cyc = 0;
    bit prev_clk = 1'b0;
    int first_ofs = -1;
    int frames = 0;
    int collect = 0;
    logic [W-1:0] acc = '0;
    logic [W-1:0] exp_tx = '0;

    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (!cs) begin
                chk("R7 pads quiet while deselected",
                    {28'd0, pins_en, ser_clk, ser_out, out_sync}, 32'd0);
                prev_clk = 1'b1;
                collect = 0;
            end else begin
                if (ser_clk && !prev_clk) begin
                    if (out_sync) begin
                        chk("R2 sync only between words", collect, 0);
                        chk("R3 line low at frame sync", {31'd0, ser_out}, 0);
                        if (first_ofs < 0) first_ofs = cyc;
                        else chk("R2 frame spacing", (cyc - first_ofs) % FCYC, 0);
                        frames++;
                        exp_tx = tx_word;
                        collect = W;
                        acc = '0;
                    end else if (collect > 0) begin
                        acc = {acc[W-2:0], ser_out};
                        collect--;
                        if (collect == 0) chk("R3 outbound word MSB first", {16'd0, acc}, {16'd0, exp_tx});
                    end else begin
                        chk("R3 line low outside word", {31'd0, ser_out}, 0);
                    end
                end
                prev_clk = ser_clk;
            end
        end
    end

    // New outbound word after each load, from a 16-bit LFSR.
    always @(negedge clk) begin
        if (tx_take) begin
            #1 tx_word = {tx_word[14:0], tx_word[15] ^ tx_word[13] ^ tx_word[12] ^ tx_word[10]};
        end
    end

    // Inbound word log.
    int rx_seen = 0;
    logic [W:0] rx_hist[$];
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_seen++;
            rx_hist.push_back({rx_is_data, rx_word});
        end
    end

    task automatic wait_rise();
        do @(negedge clk); while (ser_clk !== 1'b0);
        do @(negedge clk); while (ser_clk !== 1'b1);
    endtask

    task automatic drive_cycle(input logic f, input logic d, input logic k);
        if (cs) wait_rise();
        else repeat (DIV) @(negedge clk);
        #1;
        in_sync = f;
        ser_in = d;
        word_type = k;
    endtask

    task automatic rx_send(input logic [W-1:0] w, input logic k, input int stray_bit,
                           input bit fs_at_lsb, input logic nk, input bit send_fs);
        logic f;
        if (send_fs) drive_cycle(1'b1, 1'b0, k);
        for (int i = W - 1; i >= 0; i--) begin
            f = (i == stray_bit) || (i == 0 && fs_at_lsb);
            drive_cycle(f, w[i], f ? ((i == 0) ? nk : ~k) : 1'b0);
        end
        if (!fs_at_lsb) drive_cycle(1'b0, 1'b0, 1'b0);
    endtask

    task automatic expect_rx(input int idx, input logic [W-1:0] w, input logic k, input string tag);
        if (rx_seen > idx) chk(tag, {15'd0, rx_hist[idx]}, {15'd0, k, w});
        else chk({tag, " (missing word)"}, rx_seen, idx + 1);
    endtask

    task automatic settle();
        wait_rise();
        wait_rise();
    endtask

    task automatic sync_to_frame();
        do @(negedge clk); while (out_sync !== 1'b1);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        logic [W-1:0] w;
        // Reset state
        repeat (3) @(negedge clk);
        chk("R9 pad enable in reset", {31'd0, pins_en}, 1);
        chk("R9 outputs low in reset", {28'd0, ser_clk, ser_out, out_sync, rx_valid}, 0);
        #1 cs = 1'b0;
        @(negedge clk);
        chk("R9 pad enable follows select", {31'd0, pins_en}, 0);
        #1 cs = 1'b1;
        @(negedge clk);
        #1 rst = 1'b0;
        mon_on = 1'b1;

        // Serial clock waveform and first frame sync, edge by edge.
        for (int k = 1; k <= 50; k++) begin
            @(negedge clk);
            chk("R1 serial clock shape", {31'd0, ser_clk}, {31'd0, (k % 5 == 3) || (k % 5 == 4)});
            chk("R2 first frame sync", {31'd0, out_sync}, {31'd0, (k >= 3) && (k <= 7)});
        end

        // Inbound sweep: fixed patterns and walking ones.
        rx_send(16'h0000, 1'b0, -1, 1'b0, 1'b0, 1'b1); settle();
        expect_rx(0, 16'h0000, 1'b0, "R4/R5 all zero control");
        rx_send(16'hFFFF, 1'b1, -1, 1'b0, 1'b0, 1'b1); settle();
        expect_rx(1, 16'hFFFF, 1'b1, "R4/R5 all one data");
        rx_send(16'h8001, 1'b1, -1, 1'b0, 1'b0, 1'b1); settle();
        expect_rx(2, 16'h8001, 1'b1, "R4 end bits");
        rx_send(16'h7FFE, 1'b0, -1, 1'b0, 1'b0, 1'b1); settle();
        expect_rx(3, 16'h7FFE, 1'b0, "R4/R5 inner bits");
        for (int i = 0; i < W; i++) begin
            w = 16'h0001 << i;
            rx_send(w, i[0], -1, 1'b0, 1'b0, 1'b1); settle();
            expect_rx(4 + i, w, i[0], "R4/R5 walking one");
        end

        // Back-to-back words chained by a sync in the LSB cycle.
        base = rx_seen;
        rx_send(16'h3C5A, 1'b0, -1, 1'b1, 1'b1, 1'b1);
        rx_send(16'hC3A6, 1'b1, -1, 1'b0, 1'b0, 1'b0);
        settle();
        expect_rx(base, 16'h3C5A, 1'b0, "R6 chained first word");
        expect_rx(base + 1, 16'hC3A6, 1'b1, "R6 chained second word");

        // Stray sync in mid-word is ignored.
        base = rx_seen;
        rx_send(16'hC3A5, 1'b1, 7, 1'b0, 1'b0, 1'b1); settle();
        expect_rx(base, 16'hC3A5, 1'b1, "R6 stray sync keeps word");
        repeat (20) wait_rise();
        chk("R6 stray sync opens no word", rx_seen, base + 1);

        // Deselected for a whole word.
        base = rx_seen;
        @(negedge clk); #1 cs = 1'b0;
        rx_send(16'h1234, 1'b1, -1, 1'b0, 1'b0, 1'b1);
        @(negedge clk); #1 cs = 1'b1;
        settle();
        chk("R7 inputs ignored while deselected", rx_seen, base);

        // Select dropped in the middle of an inbound word.
        sync_to_frame();
        repeat (25) wait_rise();
        base = rx_seen;
        w = 16'h5AA5;
        drive_cycle(1'b1, 1'b0, 1'b1);
        for (int i = W - 1; i >= 8; i--) drive_cycle(1'b0, w[i], 1'b0);
        @(negedge clk); #1 cs = 1'b0;
        repeat (12) @(negedge clk);
        #1 cs = 1'b1;
        for (int i = 7; i >= 0; i--) drive_cycle(1'b0, w[i], 1'b0);
        drive_cycle(1'b0, 1'b0, 1'b0);
        settle();
        chk("R8 cut inbound word discarded", rx_seen, base);
        rx_send(16'h0F0F, 1'b1, -1, 1'b0, 1'b0, 1'b1); settle();
        expect_rx(base, 16'h0F0F, 1'b1, "R8 next word after cut");

        // Select dropped in the middle of an outbound word.
        sync_to_frame();
        repeat (6) wait_rise();
        @(negedge clk); #1 cs = 1'b0;
        repeat (10) @(negedge clk);
        #1 cs = 1'b1;
        for (int i = 0; i < 20; i++) begin
            wait_rise();
            chk("R8 cut outbound word stays low", {31'd0, ser_out}, 0);
        end

        while (frames < 5) @(negedge clk);
        chk("R2 first sync at third edge", first_ofs, 3);
        summary();
        $finish;
    end
endmodule